// File: doc/BRIEF.md
# Orbit-Aligned Input Release Gate

This block sits on the input channels of a packet-based datapath. Each channel carries one word per cycle with a data field and five flags: valid, strobe, packet start, packet end and orbit start. While the links and buffers are being set up, every channel is held in a defined idle state, so downstream logic never sees partial or misaligned traffic. Once software sets a single shared enable bit, each channel waits for its own orbit-start word and is released at that word. The first packet a channel delivers is therefore always a complete orbit-start packet, and all channels resume on orbit boundaries.

Each channel also watches the framing of the stream it carries. Any packet-structure violation sets a sticky error bit that software clears by writing a one to it. The data path adds one register stage. The control interface is a small word-addressed register file whose data width equals the channel count.

Top module: `orbit_input_gate`

## Requirements
- R1: After reset every channel is held, the enable bit reads 0, all framing-error bits read 0, and every output word is idle.
- R2: While a channel is held, its valid, start, end and orbit-start outputs are low and its strobe output is high. Its data output carries no meaning.
- R3: A held channel is released only in a cycle where the enable bit is already 1 and that channel's orbit-start input is high. An orbit-start word seen while the enable bit is 0 leaves the channel held.
- R4: On the release cycle and on every cycle after it, the channel's output word equals its input word from one clock earlier, with all fields unchanged.
- R5: Each channel is released by its own orbit-start flag, whatever the state of the other channels.
- R6: Writing 0 to bit 0 of address 0 holds every channel from the next clock edge, as shown by the held status. The outputs are idle from the edge after that.
- R7: Reads are combinational. Address 0 returns the enable in bit 0. Address 1 returns one held bit per channel, with bit i for channel i. Address 3 returns zero. The held bits are also driven on the `chan_held` port.
- R8: A channel's framing-error bit (address 2, bit i) becomes 1 one edge after any of these faults: an end flag with no open packet and no start in the same word; a start while a packet is open; or valid low on a start word, on an end word, or inside an open packet. The bit stays 1 until it is cleared.
- R9: Writing address 2 clears every error bit whose write-data bit is 1. A fault in the same cycle wins over the clear.
- R10: Back-to-back packets with no filler between them, and single-word packets with start and end in one word, raise no framing error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register word address |
| cfg_wdata | input | N_CHAN | Register write data |
| cfg_rdata | output | N_CHAN | Register read data for cfg_addr |
| in_data | input | N_CHAN*OG_DATA_W | Input data, channel i in slice i |
| in_valid | input | N_CHAN | Input valid flags |
| in_strobe | input | N_CHAN | Input strobe flags |
| in_start | input | N_CHAN | Input packet-start flags |
| in_last | input | N_CHAN | Input packet-end flags |
| in_orbit | input | N_CHAN | Input orbit-start flags |
| out_data | output | N_CHAN*OG_DATA_W | Output data |
| out_valid | output | N_CHAN | Output valid flags |
| out_strobe | output | N_CHAN | Output strobe flags |
| out_start | output | N_CHAN | Output packet-start flags |
| out_last | output | N_CHAN | Output packet-end flags |
| out_orbit | output | N_CHAN | Output orbit-start flags |
| chan_held | output | N_CHAN | Per-channel held status |
| chan_frame_err | output | N_CHAN | Per-channel sticky framing-error bits |

## Verification
A held flag stuck at 1 shows as idle output words and a 1 on `chan_held` one cycle after a qualifying orbit-start word. A held flag stuck at 0 lets filler or mid-packet words through one cycle after they enter. A packet-tracking state that drifts from the real stream shows as a framing-error bit that is set on legal traffic or stays clear on a fault. Either way it is visible on the edge after the offending word. A release taken without the enable bit, or on a word without orbit start, shows as an output word that is not an orbit-start word on the cycle where `chan_held` falls.

// File: rtl/orbit_gate_pkg.sv
package orbit_gate_pkg;

    parameter int OG_DATA_W = 32;

    typedef struct packed {
        logic [OG_DATA_W-1:0] data;
        logic                 valid;
        logic                 strobe;
        logic                 start;
        logic                 last;
        logic                 orbit;
    } og_word_t;

    typedef enum logic [1:0] {
        OG_A_CTRL = 2'd0,
        OG_A_HELD = 2'd1,
        OG_A_FERR = 2'd2,
        OG_A_RSVD = 2'd3
    } og_addr_e;

    // Word presented downstream while a channel is held.
    function automatic og_word_t og_idle_word();
        og_word_t w;
        w        = '0;
        w.strobe = 1'b1;
        return w;
    endfunction

    // Framing fault for one word, given whether a packet is currently open.
    function automatic logic og_frame_fault(input logic open_pkt, input logic valid,
                                            input logic start, input logic last);
        logic gap, dup, orphan;
        gap    = !valid && (open_pkt || start || last);
        dup    = start && open_pkt;
        orphan = last && !start && !open_pkt;
        return gap || dup || orphan;
    endfunction

    // Open-packet state after one word.
    function automatic logic og_next_open(input logic open_pkt, input logic start,
                                          input logic last);
        if (start)     return !last;
        else if (last) return 1'b0;
        else           return open_pkt;
    endfunction

endpackage

// File: rtl/og_cfg_regs.sv
module og_cfg_regs
    import orbit_gate_pkg::*;
#(
    parameter int N_CHAN = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [1:0]        addr,
    input  logic [N_CHAN-1:0] wdata,
    input  logic [N_CHAN-1:0] held,
    input  logic [N_CHAN-1:0] ferr,
    output logic              enable,
    output logic              hold_all,
    output logic [N_CHAN-1:0] ferr_clr,
    output logic [N_CHAN-1:0] rdata
);

    og_addr_e sel;
    logic     en_q;

    always_comb sel = og_addr_e'(addr);

    always_ff @(posedge clk) begin
        if (rst)                         en_q <= 1'b0;
        else if (wr && sel == OG_A_CTRL) en_q <= wdata[0];
    end

    always_comb begin
        hold_all = wr && (sel == OG_A_CTRL) && !wdata[0];
        ferr_clr = (wr && sel == OG_A_FERR) ? wdata : '0;
    end

    always_comb begin
        rdata = '0;
        unique case (sel)
            OG_A_CTRL: rdata[0] = en_q;
            OG_A_HELD: rdata    = held;
            OG_A_FERR: rdata    = ferr;
            OG_A_RSVD: rdata    = '0;
            default:   rdata    = '0;
        endcase
    end

    assign enable = en_q;

endmodule

// File: rtl/og_lane.sv
module og_lane
    import orbit_gate_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  og_word_t din,
    input  logic     enable,
    input  logic     hold_all,
    output og_word_t dout,
    output logic     held
);

    logic     held_q, held_d, release_now;
    og_word_t out_q, out_d;

    always_comb begin
        release_now = held_q && enable && din.orbit;
        out_d       = (held_q && !release_now) ? og_idle_word() : din;
        if (hold_all) held_d = 1'b1;
        else          held_d = held_q && !release_now;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= 1'b1;
            out_q  <= og_idle_word();
        end else begin
            held_q <= held_d;
            out_q  <= out_d;
        end
    end

    assign dout = out_q;
    assign held = held_q;

endmodule

// File: rtl/og_frame_mon.sv
module og_frame_mon
    import orbit_gate_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic valid,
    input  logic start,
    input  logic last,
    input  logic clr,
    output logic err
);

    logic open_q, err_q, fault;

    always_comb fault = og_frame_fault(open_q, valid, start, last);

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            open_q <= og_next_open(open_q, start, last);
            err_q  <= (err_q && !clr) || fault;
        end
    end

    assign err = err_q;

endmodule

// File: rtl/orbit_input_gate.sv
module orbit_input_gate
    import orbit_gate_pkg::*;
#(
    parameter int N_CHAN = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cfg_wr,
    input  logic [1:0]                    cfg_addr,
    input  logic [N_CHAN-1:0]             cfg_wdata,
    output logic [N_CHAN-1:0]             cfg_rdata,
    input  logic [N_CHAN*OG_DATA_W-1:0]   in_data,
    input  logic [N_CHAN-1:0]             in_valid,
    input  logic [N_CHAN-1:0]             in_strobe,
    input  logic [N_CHAN-1:0]             in_start,
    input  logic [N_CHAN-1:0]             in_last,
    input  logic [N_CHAN-1:0]             in_orbit,
    output logic [N_CHAN*OG_DATA_W-1:0]   out_data,
    output logic [N_CHAN-1:0]             out_valid,
    output logic [N_CHAN-1:0]             out_strobe,
    output logic [N_CHAN-1:0]             out_start,
    output logic [N_CHAN-1:0]             out_last,
    output logic [N_CHAN-1:0]             out_orbit,
    output logic [N_CHAN-1:0]             chan_held,
    output logic [N_CHAN-1:0]             chan_frame_err
);

    logic              ctrl_en;
    logic              hold_all;
    logic [N_CHAN-1:0] ferr_clr;

    og_cfg_regs #(.N_CHAN(N_CHAN)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr       (cfg_wr),
        .addr     (cfg_addr),
        .wdata    (cfg_wdata),
        .held     (chan_held),
        .ferr     (chan_frame_err),
        .enable   (ctrl_en),
        .hold_all (hold_all),
        .ferr_clr (ferr_clr),
        .rdata    (cfg_rdata)
    );

    for (genvar i = 0; i < N_CHAN; i++) begin : g_chan
        og_word_t w_in, w_out;

        always_comb begin
            w_in.data   = in_data[i*OG_DATA_W +: OG_DATA_W];
            w_in.valid  = in_valid[i];
            w_in.strobe = in_strobe[i];
            w_in.start  = in_start[i];
            w_in.last   = in_last[i];
            w_in.orbit  = in_orbit[i];
        end

        og_lane u_lane (
            .clk      (clk),
            .rst      (rst),
            .din      (w_in),
            .enable   (ctrl_en),
            .hold_all (hold_all),
            .dout     (w_out),
            .held     (chan_held[i])
        );

        og_frame_mon u_mon (
            .clk   (clk),
            .rst   (rst),
            .valid (in_valid[i]),
            .start (in_start[i]),
            .last  (in_last[i]),
            .clr   (ferr_clr[i]),
            .err   (chan_frame_err[i])
        );

        assign out_data[i*OG_DATA_W +: OG_DATA_W] = w_out.data;
        assign out_valid[i]  = w_out.valid;
        assign out_strobe[i] = w_out.strobe;
        assign out_start[i]  = w_out.start;
        assign out_last[i]   = w_out.last;
        assign out_orbit[i]  = w_out.orbit;
    end

endmodule

// File: rtl/og_checks.sv
module og_checks
    import orbit_gate_pkg::*;
#(
    parameter int N_CHAN = 4
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        cfg_wr,
    input logic [1:0]                  cfg_addr,
    input logic [N_CHAN-1:0]           cfg_wdata,
    input logic                        enable,
    input logic [N_CHAN*OG_DATA_W-1:0] in_data,
    input logic [N_CHAN-1:0]           in_valid,
    input logic [N_CHAN-1:0]           in_strobe,
    input logic [N_CHAN-1:0]           in_start,
    input logic [N_CHAN-1:0]           in_last,
    input logic [N_CHAN-1:0]           in_orbit,
    input logic [N_CHAN*OG_DATA_W-1:0] out_data,
    input logic [N_CHAN-1:0]           out_valid,
    input logic [N_CHAN-1:0]           out_strobe,
    input logic [N_CHAN-1:0]           out_start,
    input logic [N_CHAN-1:0]           out_last,
    input logic [N_CHAN-1:0]           out_orbit,
    input logic [N_CHAN-1:0]           chan_held,
    input logic [N_CHAN-1:0]           chan_frame_err
);

    p_hold_all_r6: assert property (@(posedge clk) disable iff (rst)
        $past(cfg_wr && cfg_addr == 2'd0 && !cfg_wdata[0]) |-> (&chan_held));

    for (genvar i = 0; i < N_CHAN; i++) begin : g_chk
        p_idle_r2: assert property (@(posedge clk) disable iff (rst)
            (chan_held[i] && $past(chan_held[i])) |->
            (!out_valid[i] && out_strobe[i] && !out_start[i] && !out_last[i] && !out_orbit[i]));

        p_release_cause_r3: assert property (@(posedge clk) disable iff (rst)
            $fell(chan_held[i]) |-> ($past(in_orbit[i]) && $past(enable) && out_orbit[i]));

        p_pass_r4: assert property (@(posedge clk) disable iff (rst)
            (!$past(chan_held[i]) || $fell(chan_held[i])) |->
            (out_data[i*OG_DATA_W +: OG_DATA_W] == $past(in_data[i*OG_DATA_W +: OG_DATA_W])
             && out_valid[i] == $past(in_valid[i]) && out_strobe[i] == $past(in_strobe[i])
             && out_start[i] == $past(in_start[i]) && out_last[i] == $past(in_last[i])
             && out_orbit[i] == $past(in_orbit[i])));

        p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
            ($past(chan_frame_err[i]) && !$past(cfg_wr && cfg_addr == 2'd2 && cfg_wdata[i]))
            |-> chan_frame_err[i]);
    end

endmodule

bind orbit_input_gate og_checks #(.N_CHAN(N_CHAN)) u_checks (
    .clk            (clk),
    .rst            (rst),
    .cfg_wr         (cfg_wr),
    .cfg_addr       (cfg_addr),
    .cfg_wdata      (cfg_wdata),
    .enable         (ctrl_en),
    .in_data        (in_data),
    .in_valid       (in_valid),
    .in_strobe      (in_strobe),
    .in_start       (in_start),
    .in_last        (in_last),
    .in_orbit       (in_orbit),
    .out_data       (out_data),
    .out_valid      (out_valid),
    .out_strobe     (out_strobe),
    .out_start      (out_start),
    .out_last       (out_last),
    .out_orbit      (out_orbit),
    .chan_held      (chan_held),
    .chan_frame_err (chan_frame_err)
);

// File: tb/orbit_input_gate_test.sv
module orbit_input_gate_test;
    import orbit_gate_pkg::*;

    localparam int N  = 4;
    localparam int DW = OG_DATA_W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic              cfg_wr = 1'b0;
    logic [1:0]        cfg_addr = '0;
    logic [N-1:0]      cfg_wdata = '0;
    logic [N-1:0]      cfg_rdata;
    logic [N*DW-1:0]   in_data = '0;
    logic [N-1:0]      in_valid = '0, in_strobe = '0, in_start = '0, in_last = '0, in_orbit = '0;
    logic [N*DW-1:0]   out_data;
    logic [N-1:0]      out_valid, out_strobe, out_start, out_last, out_orbit;
    logic [N-1:0]      chan_held, chan_frame_err;

    orbit_input_gate #(.N_CHAN(N)) uut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .in_data(in_data), .in_valid(in_valid), .in_strobe(in_strobe),
        .in_start(in_start), .in_last(in_last), .in_orbit(in_orbit), .out_data(out_data),
        .out_valid(out_valid), .out_strobe(out_strobe), .out_start(out_start),
        .out_last(out_last), .out_orbit(out_orbit), .chan_held(chan_held),
        .chan_frame_err(chan_frame_err)
    );

    int checks = 0;
    int fails  = 0;

    // Words to drive in the next step
    logic [N*DW-1:0] dd;
    logic [N-1:0]    dv, ds, dst, dl, dor;

    // Reference state
    logic            m_en;
    logic [N-1:0]    m_held, m_open, m_err;

    // Legal stream generator state
    logic [N-1:0]    g_open;
    int              g_left [N];

    task automatic check(input logic ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic set_filler();
        dv = '0; ds = '1; dst = '0; dl = '0; dor = '0; dd = '0;
    endtask

    task automatic gen_words(input logic allow_start);
        for (int i = 0; i < N; i++) begin
            dd[i*DW +: DW] = $urandom;
            ds[i] = ($urandom % 8) != 0;
            dor[i] = 1'b0; dst[i] = 1'b0; dl[i] = 1'b0; dv[i] = 1'b0;
            if (g_open[i]) begin
                dv[i] = 1'b1;
                g_left[i]--;
                if (g_left[i] == 0) begin
                    dl[i] = 1'b1;
                    g_open[i] = 1'b0;
                end
            end else if (allow_start && ($urandom % 3) == 0) begin
                dv[i] = 1'b1; dst[i] = 1'b1;
                g_left[i] = int'($urandom % 4);
                dl[i] = (g_left[i] == 0);
                g_open[i] = !dl[i];
                dor[i] = ($urandom % 5) == 0;
            end
        end
    endtask

    // One clock: drive at the falling edge, predict, check after the rising edge.
    task automatic step(input logic wr, input logic [1:0] addr, input logic [N-1:0] wdata,
                        input logic rd_chk);
        logic [N-1:0] pass, fault, clr, exp_rd;
        logic         kill;
        @(negedge clk);
        cfg_wr = wr; cfg_addr = addr; cfg_wdata = wdata;
        in_data = dd; in_valid = dv; in_strobe = ds; in_start = dst; in_last = dl; in_orbit = dor;
        kill = wr && addr == 2'd0 && !wdata[0];
        clr  = (wr && addr == 2'd2) ? wdata : '0;
        for (int i = 0; i < N; i++) begin
            logic rel;
            rel      = m_held[i] && m_en && dor[i];
            pass[i]  = !m_held[i] || rel;
            fault[i] = (!dv[i] && (m_open[i] || dst[i] || dl[i])) || (dst[i] && m_open[i])
                       || (dl[i] && !dst[i] && !m_open[i]);
            m_open[i] = dst[i] ? !dl[i] : (dl[i] ? 1'b0 : m_open[i]);
            m_held[i] = kill ? 1'b1 : (m_held[i] && !rel);
        end
        m_err = (m_err & ~clr) | fault;
        if (wr && addr == 2'd0) m_en = wdata[0];
        @(posedge clk);
        #1;
        for (int i = 0; i < N; i++) begin
            if (pass[i]) begin
                check(out_valid[i] == dv[i] && out_strobe[i] == ds[i] && out_start[i] == dst[i]
                      && out_last[i] == dl[i] && out_orbit[i] == dor[i]
                      && out_data[i*DW +: DW] == dd[i*DW +: DW], "R4 pass-through",
                      {out_data[i*DW +: DW], out_valid[i], out_strobe[i], out_start[i], out_last[i], out_orbit[i]},
                      {dd[i*DW +: DW], dv[i], ds[i], dst[i], dl[i], dor[i]});
            end else begin
                check(!out_valid[i] && out_strobe[i] && !out_start[i] && !out_last[i] && !out_orbit[i],
                      "R2 idle flags",
                      {out_valid[i], out_strobe[i], out_start[i], out_last[i], out_orbit[i]},
                      64'b01000);
            end
        end
        check(chan_held == m_held, "R7 held status", chan_held, m_held);
        check(chan_frame_err == m_err, "R8 error bits", chan_frame_err, m_err);
        if (rd_chk) begin
            unique case (addr)
                2'd0:    exp_rd = {{(N-1){1'b0}}, m_en};
                2'd1:    exp_rd = m_held;
                2'd2:    exp_rd = m_err;
                default: exp_rd = '0;
            endcase
            check(cfg_rdata == exp_rd, "R7 register read", cfg_rdata, exp_rd);
        end
    endtask

    task automatic drain();
        while (g_open != '0) begin
            gen_words(1'b0);
            step(1'b0, 2'd1, '0, 1'b1);
        end
        set_filler();
        step(1'b0, 2'd3, '0, 1'b1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240917));
        m_en = 1'b0; m_held = '1; m_open = '0; m_err = '0;
        g_open = '0;
        for (int i = 0; i < N; i++) g_left[i] = 0;
        set_filler();

        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: state straight after reset
        check(chan_held == '1, "R1 held after reset", chan_held, '1);
        check(chan_frame_err == '0, "R1 errors after reset", chan_frame_err, 0);
        check(out_valid == '0 && out_strobe == '1 && out_start == '0 && out_last == '0
              && out_orbit == '0, "R1 idle outputs", {out_valid, out_strobe}, {4'h0, 4'hf});
        check(cfg_rdata == '0, "R1 enable reads 0", cfg_rdata, 0);

        // R3: traffic with orbit words while disabled keeps every channel held
        for (int k = 0; k < 200; k++) begin
            gen_words(1'b1);
            step(1'b0, 2'(k % 4), '0, 1'b1);
        end
        check(chan_held == '1, "R3 no release while disabled", chan_held, '1);
        drain();

        // Enable, then an orbit word on channel 2 only
        set_filler();
        step(1'b1, 2'd0, 4'b0001, 1'b1);
        set_filler();
        dv[2] = 1'b1; dst[2] = 1'b1; dl[2] = 1'b1; dor[2] = 1'b1; dd[2*DW +: DW] = 32'hA5A5_0002;
        step(1'b0, 2'd1, '0, 1'b1);
        check(chan_held == 4'b1011, "R5 only channel 2 released", chan_held, 4'b1011);
        check(out_orbit[2] && out_start[2] && out_data[2*DW +: DW] == 32'hA5A5_0002,
              "R4 release word passed", out_data[2*DW +: DW], 32'hA5A5_0002);

        // Random traffic with the enable set
        for (int k = 0; k < 1500; k++) begin
            gen_words(1'b1);
            step(1'b0, 2'(k % 4), '0, 1'b1);
        end
        check(chan_held == '0, "R5 every channel released", chan_held, 0);

        // R6: disable while traffic runs
        gen_words(1'b1);
        step(1'b1, 2'd0, 4'b0000, 1'b1);
        check(chan_held == '1, "R6 held right after disable", chan_held, '1);
        gen_words(1'b1);
        step(1'b0, 2'd1, '0, 1'b1);
        check(out_orbit == '0 && out_start == '0 && out_strobe == '1, "R6 idle after disable",
              {out_orbit, out_start}, 0);
        drain();

        // R8 / R10: directed framing patterns
        set_filler();
        dv[0] = 1'b1; dl[0] = 1'b1;                 // end with no open packet
        dv[1] = 1'b1; dst[1] = 1'b1;                // open packet
        dv[2] = 1'b1; dst[2] = 1'b1;                // open packet
        dv[3] = 1'b1; dst[3] = 1'b1; dl[3] = 1'b1;  // single-word packet
        step(1'b0, 2'd2, '0, 1'b1);
        set_filler();
        dv[1] = 1'b1; dst[1] = 1'b1;                // second start while open
        dv[2] = 1'b0;                               // gap inside packet
        dv[3] = 1'b1; dst[3] = 1'b1;                // back-to-back start
        step(1'b0, 2'd2, '0, 1'b1);
        set_filler();
        dv[1] = 1'b1; dl[1] = 1'b1;
        dv[2] = 1'b1; dl[2] = 1'b1;
        dv[3] = 1'b1; dl[3] = 1'b1;
        step(1'b0, 2'd2, '0, 1'b1);
        check(chan_frame_err == 4'b0111, "R8 three fault kinds", chan_frame_err, 4'b0111);
        check(chan_frame_err[3] == 1'b0, "R10 back-to-back legal", chan_frame_err[3], 0);
        set_filler();
        step(1'b0, 2'd2, '0, 1'b1);
        check(chan_frame_err == 4'b0111, "R8 bits stay set", chan_frame_err, 4'b0111);

        // R9: clear only bit 0
        set_filler();
        step(1'b1, 2'd2, 4'b0001, 1'b0);
        set_filler();
        step(1'b0, 2'd2, '0, 1'b1);
        check(cfg_rdata == 4'b0110, "R9 write-one clear", cfg_rdata, 4'b0110);

        // Re-enable and run random traffic
        set_filler();
        step(1'b1, 2'd0, 4'b0001, 1'b1);
        for (int k = 0; k < 400; k++) begin
            gen_words(1'b1);
            step(1'b0, 2'(k % 4), '0, 1'b1);
        end
        check(cfg_rdata !== 'x, "R7 read defined", cfg_rdata, cfg_rdata);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule